// File: doc/BRIEF.md
# Software Write-Protection Command Gate

This block sits between the byte-load front end of a page-programmed memory and the page sequencer that collects bytes into the page buffer. It holds one protection bit. While the bit is clear, every byte load is passed to the sequencer. While it is set, the loads of a program cycle reach the sequencer only when the cycle opens with a fixed three-write unlock prefix. Loads that arrive without that prefix are consumed and dropped. The program cycle still ends with a commit pulse, so the sequencer runs its timer and shows busy. The commit is simply marked as not to be written.

The unlock prefix also sets the protection bit. A second three-write prefix clears it. The command writes never reach the page buffer. The bit survives the ends of program cycles and is cleared only by the disable prefix or by the initialization reset. Load periods are delimited by `period_end`, a pulse from the inter-byte timer of the sequencer. Byte loads form a valid/ready stream. A beat that is forwarded completes only when the sequencer accepts it (`ld_ready` follows `fwd_ready`). A command beat or a discarded beat is taken at once, whatever `fwd_ready` is.

Top module: `swp_gate`

## Requirements
- R1: After reset, `prot_on` is 0 and `fwd_valid` and `commit_valid` are 0.
- R2: A load period whose first three accepted loads are (0x5555,0xAA), (0x2AAA,0x55), (0x5555,0xA0) in that order sets `prot_on` in the cycle after the third write. None of these three writes is forwarded.
- R3: While `prot_on` is 0, a load that is not a matched prefix write at the start of a period is forwarded in the same cycle, with its address and data unchanged.
- R4: While `prot_on` is 1 and the current period did not open with the enable prefix, every load is accepted (`ld_ready`=1) and not forwarded. At period end `commit_valid` still pulses, with `commit_keep`=0.
- R5: While `prot_on` is 1, a period that opens with the enable prefix forwards all of its later loads, ends with `commit_keep`=1, and leaves `prot_on` at 1.
- R6: A period whose first three accepted loads are (0x5555,0xAA), (0x2AAA,0x55), (0x5555,0x20) clears `prot_on` in the cycle after the third write. The later loads of that period are forwarded.
- R7: A write that does not match the next step of any live prefix is handled as an ordinary load. It is forwarded only if the period is unlocked. The prefix writes before it have already been consumed. No prefix is recognized later in that period.
- R8: On a forwarded beat, `ld_ready` equals `fwd_ready`. On a command or discarded beat, `ld_ready` is 1 and `fwd_valid` is 0.
- R9: `commit_valid` pulses for one cycle, the cycle after `period_end`, only when that period accepted at least one load. `commit_keep` is 1 when the period was unlocked or protection was off.
- R10: `prot_on` changes only in the cycle after an accepted load. The end of a period leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low initialization reset; clears protection |
| ld_valid | input | 1 | Byte-load beat present |
| ld_ready | output | 1 | Byte-load beat taken this cycle |
| ld_addr | input | 15 | Byte-load address |
| ld_data | input | 8 | Byte-load data |
| period_end | input | 1 | Pulse: inter-byte timer expired, load period over |
| fwd_valid | output | 1 | Beat offered to the page sequencer |
| fwd_ready | input | 1 | Page sequencer takes the offered beat |
| fwd_addr | output | 15 | Forwarded address |
| fwd_data | output | 8 | Forwarded data |
| commit_valid | output | 1 | One-cycle pulse: a program cycle starts |
| commit_keep | output | 1 | Program cycle may write its data (0: timer only) |
| prot_on | output | 1 | Protection state |

## Verification
Three results have different due times. The forward decision (`fwd_valid`, `ld_ready` and the forwarded fields) is combinational on the current beat, so it is sampled one time unit after the inputs change, in the low half of the clock. `prot_on` changes one register after the accepting edge and is sampled just after that edge. `commit_valid` and `commit_keep` are registered from `period_end` and are checked after the first edge following the pulse. They are checked once more one edge later, to confirm that the pulse lasts only one cycle.

// File: rtl/swp_pkg.sv
package swp_pkg;
  typedef enum logic [1:0] {
    PH_PREFIX = 2'd0,
    PH_OPEN   = 2'd1,
    PH_ARMED  = 2'd2
  } phase_e;

  localparam int unsigned SEQ_EN  = 0;
  localparam int unsigned SEQ_DIS = 1;
  localparam int unsigned NUM_SEQ = 2;
endpackage

// File: rtl/swp_seq_match.sv
module swp_seq_match #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SEQ_LEN = 3,
  parameter int unsigned STEP_W = 2,
  parameter logic [SEQ_LEN*ADDR_W-1:0] ADDRS = '0,
  parameter logic [SEQ_LEN*DATA_W-1:0] DATAS = '0
) (
  input  logic [STEP_W-1:0] step,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              hit
);
  logic [SEQ_LEN-1:0] eq;

  for (genvar i = 0; i < SEQ_LEN; i++) begin : g_step
    assign eq[i] = (addr == ADDRS[i*ADDR_W +: ADDR_W]) &&
                   (data == DATAS[i*DATA_W +: DATA_W]);
  end

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < SEQ_LEN; i++)
      if (step == STEP_W'(i)) hit = eq[i];
  end
endmodule

// File: rtl/swp_cmd_ctrl.sv
module swp_cmd_ctrl
  import swp_pkg::*;
#(
  parameter int unsigned SEQ_LEN = 3,
  parameter int unsigned STEP_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               beat_fire,
  input  logic               period_end,
  input  logic [NUM_SEQ-1:0] hit,
  output logic [STEP_W-1:0]  step,
  output logic               is_cmd,
  output logic               armed,
  output logic               prot_on
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(SEQ_LEN - 1);

  phase_e             phase;
  logic [NUM_SEQ-1:0] alive;
  logic [NUM_SEQ-1:0] live_hit;
  logic               in_prefix;

  assign in_prefix = (phase == PH_PREFIX);
  assign live_hit  = hit & alive;
  assign is_cmd    = in_prefix && (|live_hit);
  assign armed     = (phase == PH_ARMED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_PREFIX;
      step    <= '0;
      alive   <= '1;
      prot_on <= 1'b0;
    end else begin
      if (beat_fire) begin
        if (is_cmd) begin
          if (step == LAST) begin
            phase <= PH_ARMED;
            step  <= '0;
            if (live_hit[SEQ_DIS]) prot_on <= 1'b0;
            if (live_hit[SEQ_EN])  prot_on <= 1'b1;
          end else begin
            step  <= step + 1'b1;
            alive <= live_hit;
          end
        end else if (in_prefix) begin
          phase <= PH_OPEN;
          step  <= '0;
        end
      end
      if (period_end) begin
        phase <= PH_PREFIX;
        step  <= '0;
        alive <= '1;
      end
    end
  end

  assert_step_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step <= LAST);

  assert_prot_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_fire |=> $stable(prot_on));
endmodule

// File: rtl/swp_commit.sv
module swp_commit (
  input  logic clk,
  input  logic rst_n,
  input  logic beat_fire,
  input  logic period_end,
  input  logic keep_now,
  output logic commit_valid,
  output logic commit_keep
);
  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen         <= 1'b0;
      commit_valid <= 1'b0;
      commit_keep  <= 1'b0;
    end else if (period_end) begin
      commit_valid <= seen || beat_fire;
      commit_keep  <= keep_now;
      seen         <= 1'b0;
    end else begin
      commit_valid <= 1'b0;
      if (beat_fire) seen <= 1'b1;
    end
  end

  assert_commit_timing_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> $past(period_end));
endmodule

// File: rtl/swp_gate.sv
module swp_gate
  import swp_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SEQ_LEN = 3,
  parameter logic [SEQ_LEN*ADDR_W-1:0] EN_ADDRS  = {15'h5555, 15'h2AAA, 15'h5555},
  parameter logic [SEQ_LEN*DATA_W-1:0] EN_DATAS  = {8'hA0, 8'h55, 8'hAA},
  parameter logic [SEQ_LEN*ADDR_W-1:0] DIS_ADDRS = {15'h5555, 15'h2AAA, 15'h5555},
  parameter logic [SEQ_LEN*DATA_W-1:0] DIS_DATAS = {8'h20, 8'h55, 8'hAA}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              period_end,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_data,
  output logic              commit_valid,
  output logic              commit_keep,
  output logic              prot_on
);
  localparam int unsigned STEP_W = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;

  logic [NUM_SEQ-1:0] hit;
  logic [STEP_W-1:0]  step;
  logic               is_cmd, armed, pass, beat_fire, keep_now;

  for (genvar s = 0; s < NUM_SEQ; s++) begin : g_seq
    swp_seq_match #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEQ_LEN(SEQ_LEN), .STEP_W(STEP_W),
      .ADDRS(s == SEQ_EN ? EN_ADDRS : DIS_ADDRS),
      .DATAS(s == SEQ_EN ? EN_DATAS : DIS_DATAS)
    ) u_match (
      .step(step), .addr(ld_addr), .data(ld_data), .hit(hit[s])
    );
  end

  swp_cmd_ctrl #(.SEQ_LEN(SEQ_LEN), .STEP_W(STEP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .beat_fire(beat_fire), .period_end(period_end),
    .hit(hit), .step(step), .is_cmd(is_cmd), .armed(armed), .prot_on(prot_on)
  );

  assign keep_now  = armed || !prot_on;
  assign pass      = !is_cmd && keep_now;
  assign fwd_valid = ld_valid && pass;
  assign ld_ready  = pass ? fwd_ready : 1'b1;
  assign fwd_addr  = ld_addr;
  assign fwd_data  = ld_data;
  assign beat_fire = ld_valid && ld_ready;

  swp_commit u_commit (
    .clk(clk), .rst_n(rst_n), .beat_fire(beat_fire), .period_end(period_end),
    .keep_now(keep_now), .commit_valid(commit_valid), .commit_keep(commit_keep)
  );

  assert_enable_by_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_on) |-> $past(ld_valid && ld_ready && !fwd_valid));

  assert_disable_by_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_on) |-> $past(ld_valid && ld_ready && !fwd_valid));

  assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !ld_ready) |-> (fwd_valid && !fwd_ready));
endmodule

// File: tb/sim_swp_gate.sv
module sim_swp_gate;
  localparam int CLK_PERIOD = 10;
  localparam logic [14:0] EN_A  [3] = '{15'h5555, 15'h2AAA, 15'h5555};
  localparam logic [7:0]  EN_D  [3] = '{8'hAA, 8'h55, 8'hA0};
  localparam logic [14:0] DIS_A [3] = '{15'h5555, 15'h2AAA, 15'h5555};
  localparam logic [7:0]  DIS_D [3] = '{8'hAA, 8'h55, 8'h20};

  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_valid = 1'b0, ld_ready, period_end = 1'b0, fwd_valid, fwd_ready = 1'b0;
  logic [14:0] ld_addr = '0, fwd_addr;
  logic [7:0]  ld_data = '0, fwd_data;
  logic commit_valid, commit_keep, prot_on;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // bench model of the requirements
  bit m_prot = 0, m_seen = 0;
  int m_phase = 0;  // 0 prefix, 1 open, 2 unlocked
  int m_step = 0;
  logic [1:0] m_alive = 2'b11;

  always #(CLK_PERIOD/2) clk = ~clk;

  swp_gate #(
    .EN_ADDRS({EN_A[2], EN_A[1], EN_A[0]}), .EN_DATAS({EN_D[2], EN_D[1], EN_D[0]}),
    .DIS_ADDRS({DIS_A[2], DIS_A[1], DIS_A[0]}), .DIS_DATAS({DIS_D[2], DIS_D[1], DIS_D[0]})
  ) u0 (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_data(ld_data), .period_end(period_end),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_addr(fwd_addr),
    .fwd_data(fwd_data), .commit_valid(commit_valid), .commit_keep(commit_keep),
    .prot_on(prot_on)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] hit_vec(input logic [14:0] a, input logic [7:0] d, input int s);
    hit_vec[0] = (a == EN_A[s]) && (d == EN_D[s]);
    hit_vec[1] = (a == DIS_A[s]) && (d == DIS_D[s]);
  endfunction

  task automatic beat(input logic [14:0] a, input logic [7:0] d);
    logic [1:0] h;
    bit cmd, pas, done;
    int tries;
    h = hit_vec(a, d, m_step) & m_alive;
    cmd = (m_phase == 0) && (|h);
    pas = !cmd && (m_phase == 2 || !m_prot);
    done = 0;
    tries = 0;
    while (!done) begin
      @(negedge clk);
      ld_valid = 1'b1; ld_addr = a; ld_data = d;
      fwd_ready = (tries >= 2) ? 1'b1 : 1'($urandom_range(0, 1));
      #1;
      chk(cmd ? "R2" : (pas ? "R3" : "R4"), 32'(fwd_valid), 32'(pas));
      chk("R8", 32'(ld_ready), pas ? 32'(fwd_ready) : 32'd1);
      if (pas) begin
        chk("R3", 32'(fwd_addr), 32'(a));
        chk("R3", 32'(fwd_data), 32'(d));
      end
      done = ld_ready;
      tries++;
      @(posedge clk);
    end
    #1 ld_valid = 1'b0;
    m_seen = 1;
    if (cmd) begin
      if (m_step == 2) begin
        m_phase = 2; m_step = 0;
        if (h[1]) m_prot = 0;
        if (h[0]) m_prot = 1;
      end else begin
        m_step++; m_alive = h;
      end
    end else if (m_phase == 0) begin
      m_phase = 1; m_step = 0;
    end
    chk("R2/R6/R10", 32'(prot_on), 32'(m_prot));
  endtask

  task automatic end_period();
    bit keep;
    keep = (m_phase == 2) || !m_prot;
    @(negedge clk);
    period_end = 1'b1; ld_valid = 1'b0;
    @(posedge clk);
    #1 period_end = 1'b0;
    chk("R9", 32'(commit_valid), 32'(m_seen));
    if (m_seen) chk("R9", 32'(commit_keep), 32'(keep));
    chk("R10", 32'(prot_on), 32'(m_prot));
    m_phase = 0; m_step = 0; m_alive = 2'b11; m_seen = 0;
    @(posedge clk);
    #1 chk("R9", 32'(commit_valid), 32'd0);
  endtask

  task automatic send_seq(input bit dis, input int upto);
    for (int i = 0; i < upto; i++)
      beat(dis ? DIS_A[i] : EN_A[i], dis ? DIS_D[i] : EN_D[i]);
  endtask

  task automatic rand_loads(input int n);
    for (int i = 0; i < n; i++)
      beat(15'($urandom), 8'($urandom));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1", 32'(prot_on), 32'd0);
    chk("R1", 32'(fwd_valid), 32'd0);
    chk("R1", 32'(commit_valid), 32'd0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", 32'(prot_on), 32'd0);

    // R3: unprotected plain loads
    rand_loads(3); end_period();
    // R2: enable prefix then data
    send_seq(0, 3); rand_loads(2); end_period();
    // R4: protected, no prefix
    rand_loads(3); end_period();
    // R5: protected, with prefix
    send_seq(0, 3); rand_loads(3); end_period();
    // R10: empty period keeps protection, no commit
    end_period();
    // R7: partial prefix, mismatch, later prefix ignored
    send_seq(0, 2); beat(15'h1234, 8'h77); send_seq(0, 3); end_period();
    // R6: disable prefix clears protection
    send_seq(1, 3); rand_loads(2); end_period();
    // R7: unprotected mismatch forwarded
    send_seq(1, 1); beat(15'h0040, 8'h01); send_seq(0, 3); end_period();

    for (int p = 0; p < 250; p++) begin
      int kind;
      kind = $urandom_range(0, 4);
      case (kind)
        1: send_seq(0, 3);
        2: send_seq(1, 3);
        3: begin send_seq($urandom_range(0, 1) == 1, $urandom_range(1, 2)); end
        default: ;
      endcase
      if (kind != 4) rand_loads($urandom_range(1, 5));
      end_period();
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule